// File: doc/BRIEF.md
# Link-Rate Clock Frequency Checker

This block checks that a recovered serial-link parallel clock runs at the frequency that the active link rate and lane width call for. A pulse on `start` opens one measurement window of a fixed number of reference-clock cycles. During the window, the rising edges of the clock under test are counted in that clock's own domain. When the window closes, the count is frozen and handed back to the reference domain through a toggle handshake. There it is compared with the count the link configuration predicts.

The predicted clock is the serial line rate divided by ten times the symbols carried per clock. The predicted count is that frequency times the window length divided by the reference frequency. A measurement passes when the count is within plus or minus one percent of the prediction. The reserved rate code never passes.

Top module: `link_clk_checker`

## Requirements
- R1: While `rst` is high, and at the first reference edge after it is released, `count`, `done` and `pass` are all 0. A reset applied during a window abandons that window, and no `done` follows it.
- R2: A `start` pulse seen while the block is idle opens exactly one window of `WINDOW` reference cycles. A `start` that arrives while a window is open or a result is pending is ignored. It neither restarts nor extends the window, and it adds no extra `done`.
- R3: `count` reports the number of rising edges of `clk_test` that fall inside the window. This is within a few counts of f_test × `WINDOW` / f_ref, and it saturates at all ones instead of wrapping.
- R4: The rate codes are `rate`=0 for 1.62 Gb/s, 1 for 2.7 Gb/s and 2 for 5.4 Gb/s. `quad`=0 selects 2 symbols per clock (expected 81, 135 or 270 MHz), and `quad`=1 selects 4 symbols per clock (expected 40.5, 67.5 or 135 MHz). `pass` is 1 when `count` lies within ±(expected/`TOL_DIV`) of expected = f_exp × `WINDOW` / f_ref, where `TOL_DIV`=100 gives one percent.
- R5: A count outside that band gives `pass`=0.
- R6: Rate code 3 is reserved and always gives `pass`=0, whatever the measured count.
- R7: `done` is high for exactly one reference cycle per window. `count` and `pass` change only in that cycle and hold their values until the next `done`.
- R8: `rate` and `quad` are sampled when `start` is accepted. Changing them during the window has no effect on the verdict.
- R9: The count crosses into the reference domain only after it has stopped changing. `done` follows `start` by `WINDOW` reference cycles plus a few synchronizer cycles in each domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock (100 MHz by default) |
| clk_test | input | 1 | Recovered parallel clock under test |
| rst | input | 1 | Asynchronous active-high reset for both domains |
| start | input | 1 | Opens one measurement window (reference domain) |
| rate | input | 2 | Link-rate code: 0, 1 or 2, with 3 reserved |
| quad | input | 1 | 0 = two symbols per clock, 1 = four symbols per clock |
| count | output | CNT_W | Edges of `clk_test` counted in the last window |
| done | output | 1 | One-cycle pulse when `count` and `pass` are new |
| pass | output | 1 | 1 = frequency within tolerance, 0 = fail |

## Verification
The result of a measurement is due `WINDOW` reference cycles after `start` is taken. To this is added two to three test-clock cycles for the gate synchronizer and three reference cycles for the returning toggle. At the slowest clock under test this comes to less than 40 reference cycles in total. The bench polls `done` on every falling reference edge after it drives `start`. It requires the pulse to arrive no earlier than `WINDOW` and no later than `WINDOW`+40 cycles after `start`. In that same sample it reads `count` and `pass`, and one cycle later it confirms that `done` has dropped. Checks that something is ignored (a second start, a configuration change during the window, a reset during the window) watch the ports for a further full window plus margin after the stimulus.

// File: rtl/link_clk_checker.sv
`timescale 1ns/1ps
module link_clk_checker #(
  parameter int REF_KHZ = 100000,
  parameter int WINDOW  = 10000,
  parameter int CNT_W   = 16,
  parameter int TOL_DIV = 100
) (
  input  logic             clk_ref,
  input  logic             clk_test,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       rate,
  input  logic             quad,
  output logic [CNT_W-1:0] count,
  output logic             done,
  output logic             pass
);

  localparam int TW = $clog2(WINDOW + 1);

  function automatic longint expect_cnt(input longint mbps, input longint spc);
    return (mbps * 100 * WINDOW) / (spc * REF_KHZ);
  endfunction

  localparam longint E_D0 = expect_cnt(1620, 2);
  localparam longint E_D1 = expect_cnt(2700, 2);
  localparam longint E_D2 = expect_cnt(5400, 2);
  localparam longint E_Q0 = expect_cnt(1620, 4);
  localparam longint E_Q1 = expect_cnt(2700, 4);
  localparam longint E_Q2 = expect_cnt(5400, 4);

  typedef enum logic [1:0] {IDLE, OPEN, WAIT} st_t;
  st_t st;

  logic [TW-1:0]    tmr;
  logic             gate;
  logic [1:0]       cfg_rate;
  logic             cfg_quad;
  logic [2:0]       t_s;
  logic             tog_edge;
  logic [2:0]       g_s;
  logic [CNT_W-1:0] t_cnt;
  logic             t_tog;
  longint           exp_c, lo, hi, meas;
  logic             in_band;

  // test-clock domain: counter gated by the synchronized window
  always_ff @(posedge clk_test or posedge rst) begin
    if (rst) begin
      g_s   <= '0;
      t_cnt <= '0;
      t_tog <= 1'b0;
    end else begin
      g_s <= {g_s[1:0], gate};
      if (g_s[1] && !g_s[2])
        t_cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
      else if (g_s[1] && t_cnt != {CNT_W{1'b1}})
        t_cnt <= t_cnt + 1'b1;
      if (!g_s[1] && g_s[2])
        t_tog <= ~t_tog;
    end
  end

  // reference domain: toggle synchronizer
  always_ff @(posedge clk_ref or posedge rst) begin
    if (rst) t_s <= '0;
    else     t_s <= {t_s[1:0], t_tog};
  end
  assign tog_edge = t_s[2] ^ t_s[1];

  always_comb begin
    unique case ({cfg_quad, cfg_rate})
      3'b000:  exp_c = E_D0;
      3'b001:  exp_c = E_D1;
      3'b010:  exp_c = E_D2;
      3'b100:  exp_c = E_Q0;
      3'b101:  exp_c = E_Q1;
      3'b110:  exp_c = E_Q2;
      default: exp_c = 0;
    endcase
    lo   = exp_c - exp_c / TOL_DIV;
    hi   = exp_c + exp_c / TOL_DIV;
    meas = longint'(t_cnt);
  end
  assign in_band = (cfg_rate != 2'b11) && (meas >= lo) && (meas <= hi);

  always_ff @(posedge clk_ref or posedge rst) begin
    if (rst) begin
      st       <= IDLE;
      tmr      <= '0;
      gate     <= 1'b0;
      cfg_rate <= 2'b00;
      cfg_quad <= 1'b0;
      count    <= '0;
      done     <= 1'b0;
      pass     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        IDLE: if (start) begin
          cfg_rate <= rate;
          cfg_quad <= quad;
          tmr      <= '0;
          gate     <= 1'b1;
          st       <= OPEN;
        end
        OPEN: if (tmr == TW'(WINDOW - 1)) begin
          gate <= 1'b0;
          st   <= WAIT;
        end else begin
          tmr <= tmr + 1'b1;
        end
        WAIT: if (tog_edge) begin
          count <= t_cnt;
          pass  <= in_band;
          done  <= 1'b1;
          st    <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r7_done_single: assert property (@(posedge clk_ref) disable iff (rst)
    done |=> !done);

  a_r7_result_held: assert property (@(posedge clk_ref) disable iff (rst)
    !done |-> ($stable(count) && $stable(pass)));

  a_r6_reserved_fails: assert property (@(posedge clk_ref) disable iff (rst)
    (done && cfg_rate == 2'b11) |-> !pass);

  a_r9_count_frozen: assert property (@(posedge clk_ref) disable iff (rst)
    (st == WAIT && tog_edge) |-> $stable(t_cnt));

  a_r3_saturate: assert property (@(posedge clk_test) disable iff (rst)
    (g_s[1] && g_s[2] && t_cnt == {CNT_W{1'b1}}) |=> t_cnt == {CNT_W{1'b1}});

  a_r2_gate_closed_idle: assert property (@(posedge clk_ref) disable iff (rst)
    (st == IDLE) |-> !gate);

endmodule

// File: tb/sim_link_clk_checker.sv
`timescale 1ns/1ps
module sim_link_clk_checker;
  localparam int W  = 2000;
  localparam int RK = 200000;
  localparam int CW = 16;

  logic clk = 1'b0, tclk = 1'b0, rst = 1'b1, start = 1'b0, quad = 1'b0;
  logic [1:0] rate = 2'b00;
  logic [CW-1:0] count;
  logic done, pass;
  real thalf = 5.0;
  int vec = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  always #(thalf) tclk = ~tclk;

  link_clk_checker #(.REF_KHZ(RK), .WINDOW(W), .CNT_W(CW), .TOL_DIV(100)) u0 (
    .clk_ref(clk), .clk_test(tclk), .rst(rst), .start(start),
    .rate(rate), .quad(quad), .count(count), .done(done), .pass(pass));

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic set_freq(input real fk);
    thalf = 5.0e5 / fk;
    repeat (20) @(negedge clk);
  endtask

  function automatic real nom(input int r, input bit q);
    real mb;
    mb = (r == 0) ? 1620.0 : (r == 1) ? 2700.0 : (r == 2) ? 5400.0 : 2700.0;
    return mb * 100.0 / (q ? 4.0 : 2.0);
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 1;
    while (!done && n < W + 60) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run(input int r, input bit q, input real fk, input bit exp_pass, input string tag);
    int n, e;
    set_freq(fk);
    rate = 2'(r);
    quad = q;
    pulse_start();
    wait_done(n);
    chk(done && n >= W && n <= W + 40, "R9 done latency", n, W);
    e = int'(fk * W / RK);
    chk(int'(count) >= e - 3 && int'(count) <= e + 3, "R3 edge count", int'(count), e);
    chk(pass == exp_pass, tag, int'(pass), int'(exp_pass));
    @(negedge clk);
    chk(!done, "R7 done one cycle", int'(done), 0);
  endtask

  initial begin
    int n;
    logic [CW-1:0] held_c;
    logic held_p;
    bit seen;
    repeat (5) @(negedge clk);
    chk(count == 0, "R1 count in reset", int'(count), 0);
    chk(!done, "R1 done in reset", int'(done), 0);
    chk(!pass, "R1 pass in reset", int'(pass), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(count == 0 && !done && !pass, "R1 after release", int'(pass), 0);
    repeat (3) @(negedge clk);

    for (int r = 0; r < 3; r++) begin
      for (int q = 0; q < 2; q++) begin
        run(r, q[0], nom(r, q[0]),         1'b1, "R4 nominal passes");
        run(r, q[0], nom(r, q[0]) * 1.005, 1'b1, "R4 inside band passes");
        run(r, q[0], nom(r, q[0]) * 1.03,  1'b0, "R5 fast clock fails");
        run(r, q[0], nom(r, q[0]) * 0.97,  1'b0, "R5 slow clock fails");
      end
    end
    run(3, 1'b0, 135000.0, 1'b0, "R6 reserved code fails");
    run(3, 1'b1, 135000.0, 1'b0, "R6 reserved code fails");

    // second start during a window is ignored
    set_freq(nom(1, 1'b0));
    rate = 2'd1; quad = 1'b0;
    pulse_start();
    repeat (499) @(negedge clk);
    pulse_start();
    wait_done(n);
    n = n + 500;
    chk(done && n >= W && n <= W + 40, "R2 window not restarted", n, W);
    chk(pass == 1'b1, "R2 verdict", int'(pass), 1);
    seen = 1'b0;
    repeat (W + 60) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(!seen, "R2 no extra done", int'(seen), 0);

    // configuration change during the window has no effect
    set_freq(nom(0, 1'b0));
    rate = 2'd0; quad = 1'b0;
    pulse_start();
    repeat (300) @(negedge clk);
    rate = 2'd2; quad = 1'b1;
    wait_done(n);
    n = n + 300;
    chk(done && n <= W + 340, "R8 done arrives", n, W);
    chk(pass == 1'b1, "R8 latched config", int'(pass), 1);

    // result held between windows
    held_c = count;
    held_p = pass;
    repeat (200) @(negedge clk);
    chk(count == held_c, "R7 count held", int'(count), int'(held_c));
    chk(pass == held_p, "R7 pass held", int'(pass), int'(held_p));

    // reset during a window
    rate = 2'd0; quad = 1'b0;
    pulse_start();
    repeat (300) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(count == 0 && !done && !pass, "R1 reset mid-window", int'(count), 0);
    rst = 1'b0;
    seen = 1'b0;
    repeat (W + 60) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(!seen, "R1 abandoned window", int'(seen), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vec++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule